// File: doc/BRIEF.md
# Daisy-Chained Converter Readout Host

This block is the host side of a chain of serial sampling converters that share one conversion strobe and one shift clock. The converters are wired output to input, so the chain acts as one long shift register. On a start request the host raises the conversion strobe while the shift clock is low. It then waits a fixed number of system-clock cycles for the conversion to finish. After that it issues exactly sixteen shift-clock pulses per device and collects the serial return line.

The first bit of the chain is already on the return line when the conversion ends, before any clock edge. The host samples each bit in the cycle where the shift clock falls, before the converters move the next bit out. Each 16-bit result is delivered MSB first as a one-cycle strobe with the word and the position of its device. The device closest to the host is position 0. The strobe is dropped together with the last falling clock edge. After that the host holds off new requests for a programmable acquisition gap, so a long chain lowers the highest conversion rate. The clock high and low times, the conversion wait and the gap are parameters counted in system-clock cycles.

Top module: `chain_readout_host`

## Requirements
- R1: While reset is asserted and right after it, conv_o, sclk_o, busy_o and word_valid_o are all 0.
- R2: A start_i sampled while idle raises conv_o with sclk_o at 0. sclk_o stays 0 until its first rise, exactly CONV_CYC + SCLK_LO cycles after conv_o rose.
- R3: Each conversion issues exactly WORD_W × N_DEV shift-clock pulses. Each pulse is high for SCLK_HI cycles and low for SCLK_LO cycles.
- R4: conv_o stays high through the whole readback and falls on the same clock edge as the last falling edge of sclk_o. sclk_o is never high while conv_o is low.
- R5: The level on miso_i is taken on each edge where sclk_o falls. The level present before the first fall is the first bit. Bits fill each word MSB first, so bit 15 of the word is the first bit received.
- R6: The word of position k (k = 0 is the device nearest the host) is presented on word_o with word_idx_o = k. word_valid_o is high for one cycle, starting on the same edge as the 16·(k+1)-th fall of sclk_o.
- R7: busy_o is high from the accepted start until ACQ_CYC cycles after conv_o falls. A start_i that arrives while busy_o is high is ignored and starts no conversion.
- R8: After conv_o falls it stays low for at least ACQ_CYC + 1 cycles before it can rise again, even when start_i is held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| busy_o | output | 1 | A conversion, readback or acquisition gap is in progress |
| conv_o | output | 1 | Conversion strobe to all converters |
| sclk_o | output | 1 | Shift clock to all converters |
| miso_i | input | 1 | Serial return line from the converter nearest the host |
| word_o | output | WORD_W | Collected result word |
| word_valid_o | output | 1 | One-cycle strobe for word_o and word_idx_o |
| word_idx_o | output | IDX_W | Chain position of the presented word |

## Verification
Counted from the edge where conv_o rises, the first shift-clock rise is due exactly CONV_CYC + SCLK_LO cycles later. Each word strobe is due on the edge of the 16·(k+1)-th clock fall. conv_o must fall on the edge of the final fall. busy_o must drop when conv_o has been low for ACQ_CYC + 1 sampled cycles. The bench samples at the falling system-clock edge and counts shift-clock rises and falls itself, so every check compares against these counts on the exact cycle. A scoreboard queue filled by the driver is compared with each word as it appears. A start pulse during the readback and a start held high across two conversions test the rejection and the minimum gap.

// File: rtl/chain_host_pkg.sv
package chain_host_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2,
    ST_GAP  = 2'd3
  } host_state_e;

  // total number of shift clocks for a chain
  function automatic int chain_bits(input int n_dev, input int word_w);
    return n_dev * word_w;
  endfunction

  // chain position that a given bit number belongs to
  function automatic int word_of_bit(input int bit_no, input int word_w);
    return bit_no / word_w;
  endfunction

  // true when the bit number closes a word
  function automatic bit closes_word(input int bit_no, input int word_w);
    return (bit_no % word_w) == (word_w - 1);
  endfunction

endpackage

// File: rtl/chain_host_seq.sv
module chain_host_seq
  import chain_host_pkg::*;
#(
  parameter int CONV_CYC   = 20,
  parameter int ACQ_CYC    = 8,
  parameter int TOTAL_BITS = 48,
  localparam int BIT_W     = (TOTAL_BITS > 1) ? $clog2(TOTAL_BITS) : 1,
  localparam int TMR_MAX   = (CONV_CYC > ACQ_CYC) ? CONV_CYC : ACQ_CYC,
  localparam int TMR_W     = $clog2(TMR_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             fall_evt,
  output logic             read_en,
  output logic             last_fall,
  output logic [BIT_W-1:0] bit_no,
  output logic             busy_o,
  output logic             conv_o
);

  host_state_e      state;
  logic [TMR_W-1:0] tmr;

  assign last_fall = fall_evt && (bit_no == BIT_W'(TOTAL_BITS - 1));
  assign read_en   = (state == ST_READ);
  assign busy_o    = (state != ST_IDLE);
  assign conv_o    = (state == ST_CONV) || (state == ST_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      tmr    <= '0;
      bit_no <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_i) begin
          state  <= ST_CONV;
          tmr    <= '0;
          bit_no <= '0;
        end
        ST_CONV: if (tmr == TMR_W'(CONV_CYC - 1)) begin
          state <= ST_READ;
          tmr   <= '0;
        end else begin
          tmr <= tmr + 1'b1;
        end
        ST_READ: if (fall_evt) begin
          if (last_fall) state  <= ST_GAP;
          else           bit_no <= bit_no + 1'b1;
        end
        ST_GAP: if (tmr == TMR_W'(ACQ_CYC - 1)) begin
          state <= ST_IDLE;
          tmr   <= '0;
        end else begin
          tmr <= tmr + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_cnv_rise_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_o) |-> ($past(state) == ST_IDLE && $past(start_i)));

  assert_cnv_drop_on_last_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_o) |-> $past(last_fall));

  assert_busy_covers_cnv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_o |-> busy_o);

endmodule

// File: rtl/chain_sclk_gen.sv
module chain_sclk_gen #(
  parameter int SCLK_HI = 2,
  parameter int SCLK_LO = 2,
  localparam int PH_MAX = (SCLK_HI > SCLK_LO) ? SCLK_HI : SCLK_LO,
  localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk_o,
  output logic fall_evt
);

  logic [PH_W-1:0] ph;

  assign fall_evt = en && sclk_o && (ph == PH_W'(SCLK_HI - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      sclk_o <= 1'b0;
      ph     <= '0;
    end else if (!sclk_o) begin
      if (ph == PH_W'(SCLK_LO - 1)) begin
        sclk_o <= 1'b1;
        ph     <= '0;
      end else begin
        ph <= ph + 1'b1;
      end
    end else begin
      if (fall_evt) begin
        sclk_o <= 1'b0;
        ph     <= '0;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  assert_fall_follows_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fall_evt) |=> !sclk_o);

endmodule

// File: rtl/chain_deser.sv
module chain_deser
  import chain_host_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int N_DEV  = 3,
  localparam int TOTAL = N_DEV * WORD_W,
  localparam int BIT_W = (TOTAL > 1) ? $clog2(TOTAL) : 1,
  localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_evt,
  input  logic [BIT_W-1:0]  bit_no,
  input  logic              miso_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic [IDX_W-1:0]  word_idx_o
);

  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] next_word;
  logic              word_end;

  assign next_word = {shreg[WORD_W-2:0], miso_i};
  assign word_end  = fall_evt && closes_word(int'(bit_no), WORD_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg        <= '0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
      word_idx_o   <= '0;
    end else begin
      word_valid_o <= word_end;
      if (fall_evt) shreg <= next_word;
      if (word_end) begin
        word_o     <= next_word;
        word_idx_o <= IDX_W'(word_of_bit(int'(bit_no), WORD_W));
      end
    end
  end

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  assert_idx_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (int'(word_idx_o) < N_DEV));

endmodule

// File: rtl/chain_readout_host.sv
module chain_readout_host
  import chain_host_pkg::*;
#(
  parameter int N_DEV    = 3,
  parameter int WORD_W   = 16,
  parameter int SCLK_HI  = 2,
  parameter int SCLK_LO  = 2,
  parameter int CONV_CYC = 20,
  parameter int ACQ_CYC  = 8,
  localparam int TOTAL   = N_DEV * WORD_W,
  localparam int BIT_W   = (TOTAL > 1) ? $clog2(TOTAL) : 1,
  localparam int IDX_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              conv_o,
  output logic              sclk_o,
  input  logic              miso_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic [IDX_W-1:0]  word_idx_o
);

  logic             read_en;
  logic             fall_evt;
  logic             last_fall;
  logic [BIT_W-1:0] bit_no;

  chain_host_seq #(
    .CONV_CYC  (CONV_CYC),
    .ACQ_CYC   (ACQ_CYC),
    .TOTAL_BITS(chain_bits(N_DEV, WORD_W))
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .fall_evt (fall_evt),
    .read_en  (read_en),
    .last_fall(last_fall),
    .bit_no   (bit_no),
    .busy_o   (busy_o),
    .conv_o   (conv_o)
  );

  chain_sclk_gen #(
    .SCLK_HI(SCLK_HI),
    .SCLK_LO(SCLK_LO)
  ) u_sclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (read_en),
    .sclk_o  (sclk_o),
    .fall_evt(fall_evt)
  );

  chain_deser #(
    .WORD_W(WORD_W),
    .N_DEV (N_DEV)
  ) u_deser (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_evt    (fall_evt),
    .bit_no      (bit_no),
    .miso_i      (miso_i),
    .word_o      (word_o),
    .word_valid_o(word_valid_o),
    .word_idx_o  (word_idx_o)
  );

  // run-length counters used only by the checks below
  logic [15:0] hi_run;
  logic [15:0] lo_run;
  logic        seen_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run    <= '0;
      lo_run    <= '0;
      seen_fall <= 1'b0;
    end else begin
      hi_run <= sclk_o ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
      lo_run <= conv_o ? '0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1);
      if ($fell(conv_o)) seen_fall <= 1'b1;
    end
  end

  assert_sclk_inside_cnv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> conv_o);

  assert_cnv_rise_sclk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_o) |-> !sclk_o);

  assert_sclk_high_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> (hi_run == 16'(SCLK_HI)));

  assert_acq_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(conv_o) && seen_fall) |-> (lo_run >= 16'(ACQ_CYC)));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!conv_o && !sclk_o && !busy_o && !word_valid_o));

endmodule

// File: tb/chain_readout_host_bench.sv
module chain_readout_host_bench;

  localparam int N_DEV    = 3;
  localparam int WORD_W   = 16;
  localparam int SCLK_HI  = 2;
  localparam int SCLK_LO  = 2;
  localparam int CONV_CYC = 20;
  localparam int ACQ_CYC  = 8;
  localparam int TOT      = N_DEV * WORD_W;
  localparam int IDX_W    = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam int N_RUNS   = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              busy_o, conv_o, sclk_o, miso_i;
  logic [WORD_W-1:0] word_o;
  logic              word_valid_o;
  logic [IDX_W-1:0]  word_idx_o;

  always #2 clk = ~clk;

  chain_readout_host #(
    .N_DEV(N_DEV), .WORD_W(WORD_W), .SCLK_HI(SCLK_HI), .SCLK_LO(SCLK_LO),
    .CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC)
  ) u_chain_readout_host (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .conv_o(conv_o), .sclk_o(sclk_o), .miso_i(miso_i), .word_o(word_o),
    .word_valid_o(word_valid_o), .word_idx_o(word_idx_o)
  );

  // converter chain model: position 0 occupies the top bits
  logic [TOT-1:0] conv_data [N_RUNS];
  logic [TOT-1:0] chain = '0;
  int             mdl_n = 0;
  assign miso_i = chain[TOT-1];
  always @(posedge conv_o) begin
    chain = conv_data[mdl_n];
    mdl_n++;
  end
  always @(negedge sclk_o) #1 chain = chain << 1;

  int n_cmp = 0, n_bad = 0;
  int exp_word[$];
  int exp_idx[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor state
  int n_conv = 0, cyc = 0, rises = 0, falls = 0, low_run = 0, n_words = 0;
  logic p_cnv = 1'b0, p_sclk = 1'b0, p_valid = 1'b0, p_busy = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (conv_o && !p_cnv) begin
        chk(!sclk_o, "R2 sclk low at conv rise", sclk_o, 0);
        if (n_conv > 0) chk(low_run >= ACQ_CYC + 1, "R8 gap", low_run, ACQ_CYC + 1);
        chk(busy_o, "R7 busy at start", busy_o, 1);
        n_conv++; cyc = 0; rises = 0; falls = 0;
      end
      if (conv_o) low_run = 0; else low_run++;
      if (sclk_o && !p_sclk) begin
        if (rises == 0) chk(cyc == CONV_CYC + SCLK_LO, "R2 first rise", cyc, CONV_CYC + SCLK_LO);
        rises++;
      end
      if (!sclk_o && p_sclk) falls++;
      if (!conv_o && p_cnv) begin
        chk(p_sclk && !sclk_o, "R4 conv drop on last fall", sclk_o, 0);
        chk(falls == TOT, "R3 fall count", falls, TOT);
        chk(rises == TOT, "R3 rise count", rises, TOT);
      end
      if (word_valid_o) begin
        n_words++;
        chk(!p_valid, "R6 one-cycle strobe", p_valid, 0);
        chk(falls == WORD_W * (int'(word_idx_o) + 1) && p_sclk && !sclk_o,
            "R6 strobe timing", falls, WORD_W * (int'(word_idx_o) + 1));
        if (exp_word.size() == 0) begin
          chk(1'b0, "R6 unexpected word", int'(word_o), 0);
        end else begin
          int ew, ei;
          ew = exp_word.pop_front();
          ei = exp_idx.pop_front();
          chk(int'(word_idx_o) == ei, "R6 index", int'(word_idx_o), ei);
          chk(int'(word_o) == ew, "R5 word", int'(word_o), ew);
        end
      end
      if (!busy_o && p_busy) chk(low_run == ACQ_CYC + 1, "R7 busy release", low_run, ACQ_CYC + 1);
      p_cnv = conv_o; p_sclk = sclk_o; p_valid = word_valid_o; p_busy = busy_o;
    end
  end

  task automatic push_exp(input int run);
    for (int d = 0; d < N_DEV; d++) begin
      exp_word.push_back(int'(conv_data[run][TOT-1-WORD_W*d -: WORD_W]));
      exp_idx.push_back(d);
    end
  endtask

  task automatic single_conv(input int run);
    push_exp(run);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (CONV_CYC + 30) @(negedge clk);
    start_i = 1'b1;           // arrives mid-readback, must be ignored (R7)
    @(negedge clk) start_i = 1'b0;
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog actual=hung expected=idle");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    conv_data[0] = {16'hFFFF, 16'h0000, 16'h8001};
    conv_data[1] = {16'h0000, 16'hFFFF, 16'h7FFE};
    for (int r = 2; r < N_RUNS; r++)
      for (int d = 0; d < N_DEV; d++)
        conv_data[r][TOT-1-WORD_W*d -: WORD_W] = 16'(16'h3C5A + 16'h1F31 * (r * 3 + d));

    repeat (3) @(negedge clk);
    chk(!conv_o && !sclk_o && !busy_o && !word_valid_o, "R1 in reset",
        {conv_o, sclk_o, busy_o, word_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!conv_o && !sclk_o && !busy_o && !word_valid_o, "R1 after reset",
        {conv_o, sclk_o, busy_o, word_valid_o}, 0);
    p_cnv = conv_o; p_sclk = sclk_o; p_valid = word_valid_o; p_busy = busy_o;

    single_conv(0);
    single_conv(1);

    // start held high across two conversions: minimum gap (R8)
    push_exp(2);
    push_exp(3);
    @(negedge clk) start_i = 1'b1;
    while (n_conv < N_RUNS) @(posedge clk);
    @(negedge clk) start_i = 1'b0;
    while (busy_o) @(negedge clk);
    repeat (5) @(negedge clk);

    chk(n_conv == N_RUNS, "R7 rejected starts", n_conv, N_RUNS);
    chk(n_words == N_RUNS * N_DEV, "R6 word count", n_words, N_RUNS * N_DEV);
    chk(exp_word.size() == 0, "R5 scoreboard drained", exp_word.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule